// File: doc/BRIEF.md
# Receive Sampling Point Tuning Sweep Controller

This block picks the receive sampling delay for a high-speed eMMC link in hardware. After an accepted start, it walks a 6-bit tune setting upward from zero, one trial per value. Each trial writes the value into the tune field of a 16-bit control word together with a self-clearing update flag. It then waits for the PHY to confirm the new delay, asks an external command engine to run one tuning-block exchange, and records whether that exchange came back clean.

While it sweeps, the block keeps the length of the current run of clean trials and the longest run seen so far, together with the index where that longest run ended. When the last trial is done it writes the midpoint of the longest run back through the same update handshake and raises a done flag. If no trial came back clean, it raises an error flag instead and leaves the tune field alone. The control word also holds a 3-bit bus-timing mode field. Software writes this field directly, and the block accepts only the defined codes.

A start is honoured only when the attached card is eMMC and the requested operation is the HS200 tuning command. Any other start is refused and reported as an error.

Top module: `sweep_tuner`

## Requirements
- R1: After reset the control word reads 0, and testReq, doneOut and errOut are all low.
- R2: A start pulse in idle with cardIsEmmc or hs200Op low runs no trial and leaves the control word unchanged. One cycle later errOut reads 1 and doneOut reads 0.
- R3: Trial k writes k into ctrlReg[13:8] and sets ctrlReg[15]. The cycle after phyAck, bit 15 reads 0 and testReq rises. testReq stays high until a testDone pulse.
- R4: If no phyAck comes within APPLY_TIMEOUT cycles of the update flag rising, bit 15 clears, the trial counts as failed, and testReq is not raised for that value. While bit 15 is set, testReq is low.
- R5: A clean trial adds one to the current run, and a failed trial sets it to zero. The best run and its end index change only when the current run becomes strictly longer, so of two equal runs the earliest is kept.
- R6: After the last trial, if any trial passed, ctrlReg[13:8] takes the value (best end index − best length / 2), using integer division, with bit 15 set. The cycle after phyAck, bit 15 clears and doneOut reads 1. If that update times out, errOut reads 1 instead.
- R7: If every trial failed, errOut reads 1, doneOut stays 0, bit 15 stays 0 and the tune field keeps the last swept value.
- R8: A start pulse while a sweep is running has no effect on its sequence or result.
- R9: ctrlReg[2:0] holds the mode. modeWe loads modeIn when it is one of 0 (SD/legacy), 2 (eMMC SDR), 3 (eMMC DDR), 4 (HS200), 5 (HS400) or 6 (HS400 enhanced strobe). Codes 1 and 7 are ignored.
- R10: Only the values 0 to SWEEP_LEN−1 (0 to 39 by default) are swept, in ascending order, and the tune field never holds a larger value.
- R11: doneOut and errOut are low throughout a sweep, are never high together, and keep their value in idle until the next start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Start pulse for a tuning sweep |
| cardIsEmmc | input | 1 | Attached card is eMMC |
| hs200Op | input | 1 | Requested operation is the HS200 tuning command |
| modeWe | input | 1 | Write strobe for the mode field |
| modeIn | input | 3 | New mode code |
| phyAck | input | 1 | PHY reports the pending tune value in effect |
| testDone | input | 1 | Command engine finished the tuning-block test |
| testPass | input | 1 | Test result, valid with testDone |
| ctrlReg | output | 16 | Control word: bit 15 update flag, 13:8 tune, 2:0 mode |
| testReq | output | 1 | Request one tuning-block test |
| doneOut | output | 1 | Sweep finished and centre value applied |
| errOut | output | 1 | Start refused, no passing value, or final update timed out |

## Verification
The assertions assume that phyAck and testDone are single-cycle pulses and that testPass is meaningful only alongside testDone. They also assume that the command engine never reports a result unless testReq is high. The bench's responder follows the control word and testReq directly. It acknowledges each update after a delay that depends on the trial index, leaves chosen updates unacknowledged to force timeouts, and answers tests only while a request is pending. It also sends stray phyAck pulses during tests and start pulses during sweeps, and these must be ignored.

// File: rtl/sweep_tuner_pkg.sv
package sweep_tuner_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_APPLY  = 3'd1,
    ST_TEST   = 3'd2,
    ST_EVAL   = 3'd3,
    ST_SETTLE = 3'd4
  } sweepState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic beginRun;    // clear run state, load value 0, raise update flag
    logic stepNext;    // advance index, load it, raise update flag
    logic loadCentre;  // load centre of best run, raise update flag
    logic clearUpd;    // drop the update flag
    logic trialPass;   // extend current run
    logic trialFail;   // break current run
  } sweepCmd_t;

  localparam int CTRL_W   = 16;
  localparam int UPD_BIT  = 15;
  localparam int TUNE_LSB = 8;
  localparam int MODE_W   = 3;

  function automatic logic modeIsLegal(input logic [MODE_W-1:0] code);
    case (code)
      3'd0, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6: return 1'b1;
      default:                             return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/sweep_datapath.sv
module sweep_datapath
  import sweep_tuner_pkg::*;
#(
  parameter int TUNE_W        = 6,
  parameter int SWEEP_LEN     = 40,
  parameter int APPLY_TIMEOUT = 250
) (
  input  logic                clk,
  input  logic                rstN,
  input  sweepCmd_t           cmd,
  input  logic                modeWe,
  input  logic [MODE_W-1:0]   modeIn,
  output logic                isLast,
  output logic                noPass,
  output logic                applyTimeout,
  output logic [CTRL_W-1:0]   ctrlReg
);

  localparam int LAST  = SWEEP_LEN - 1;
  localparam int CNT_W = $clog2(SWEEP_LEN + 1);
  localparam int TMR_W = $clog2(APPLY_TIMEOUT + 1);

  logic [TUNE_W-1:0] idx, tune, endIdx, centre;
  logic              upd;
  logic [TMR_W-1:0]  timer;
  logic [CNT_W-1:0]  curRun, bestRun, nextRun;
  logic [MODE_W-1:0] mode;
  logic              anyLoad;

  assign nextRun = curRun + 1'b1;
  assign centre  = endIdx - TUNE_W'(bestRun >> 1);
  assign anyLoad = cmd.beginRun | cmd.stepNext | cmd.loadCentre;

  // index, tune value and update flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx  <= '0;
      tune <= '0;
      upd  <= 1'b0;
    end else begin
      if (cmd.beginRun) begin
        idx  <= '0;
        tune <= '0;
        upd  <= 1'b1;
      end else if (cmd.stepNext) begin
        idx  <= idx + 1'b1;
        tune <= idx + 1'b1;
        upd  <= 1'b1;
      end else if (cmd.loadCentre) begin
        tune <= centre;
        upd  <= 1'b1;
      end else if (cmd.clearUpd) begin
        upd  <= 1'b0;
      end
    end
  end

  // update wait timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        timer <= '0;
    else if (anyLoad) timer <= '0;
    else if (upd)     timer <= timer + 1'b1;
  end

  // run tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curRun  <= '0;
      bestRun <= '0;
      endIdx  <= '0;
    end else if (cmd.beginRun) begin
      curRun  <= '0;
      bestRun <= '0;
      endIdx  <= '0;
    end else if (cmd.trialPass) begin
      curRun <= nextRun;
      if (nextRun > bestRun) begin
        bestRun <= nextRun;
        endIdx  <= idx;
      end
    end else if (cmd.trialFail) begin
      curRun <= '0;
    end
  end

  // mode field
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               mode <= '0;
    else if (modeWe && modeIsLegal(modeIn))  mode <= modeIn;
  end

  assign isLast       = (idx == TUNE_W'(LAST));
  assign noPass       = (bestRun == '0);
  assign applyTimeout = upd && (timer == TMR_W'(APPLY_TIMEOUT - 1));

  always_comb begin
    ctrlReg                         = '0;
    ctrlReg[UPD_BIT]                = upd;
    ctrlReg[TUNE_LSB +: TUNE_W]     = tune;
    ctrlReg[MODE_W-1:0]             = mode;
  end

  AST_TUNE_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    tune <= TUNE_W'(LAST)); // R10
  AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    curRun <= bestRun); // R5
  AST_LOAD_RAISES_UPD: assert property (@(posedge clk) disable iff (!rstN)
    anyLoad |=> upd); // R3
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    modeIsLegal(mode)); // R9

endmodule

// File: rtl/sweep_ctrl.sv
module sweep_ctrl
  import sweep_tuner_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      cardIsEmmc,
  input  logic      hs200Op,
  input  logic      phyAck,
  input  logic      testDone,
  input  logic      testPass,
  input  logic      isLast,
  input  logic      noPass,
  input  logic      applyTimeout,
  output sweepCmd_t cmd,
  output logic      testReq,
  output logic      doneOut,
  output logic      errOut
);

  sweepState_t state, nextState;
  logic setDone, setErr, clrStat;

  always_comb begin
    nextState = state;
    cmd       = '0;
    setDone   = 1'b0;
    setErr    = 1'b0;
    clrStat   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          if (cardIsEmmc && hs200Op) begin
            cmd.beginRun = 1'b1;
            clrStat      = 1'b1;
            nextState    = ST_APPLY;
          end else begin
            setErr = 1'b1;
          end
        end
      end
      ST_APPLY: begin
        if (phyAck) begin
          cmd.clearUpd = 1'b1;
          nextState    = ST_TEST;
        end else if (applyTimeout) begin
          cmd.clearUpd  = 1'b1;
          cmd.trialFail = 1'b1;
          nextState     = ST_EVAL;
        end
      end
      ST_TEST: begin
        if (testDone) begin
          cmd.trialPass = testPass;
          cmd.trialFail = !testPass;
          nextState     = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (isLast) begin
          if (noPass) begin
            setErr    = 1'b1;
            nextState = ST_IDLE;
          end else begin
            cmd.loadCentre = 1'b1;
            nextState      = ST_SETTLE;
          end
        end else begin
          cmd.stepNext = 1'b1;
          nextState    = ST_APPLY;
        end
      end
      ST_SETTLE: begin
        if (phyAck) begin
          cmd.clearUpd = 1'b1;
          setDone      = 1'b1;
          nextState    = ST_IDLE;
        end else if (applyTimeout) begin
          cmd.clearUpd = 1'b1;
          setErr       = 1'b1;
          nextState    = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      doneOut <= 1'b0;
      errOut  <= 1'b0;
    end else begin
      state <= nextState;
      if (clrStat) begin
        doneOut <= 1'b0;
        errOut  <= 1'b0;
      end else if (setDone) begin
        doneOut <= 1'b1;
      end else if (setErr) begin
        errOut  <= 1'b1;
        doneOut <= 1'b0;
      end
    end
  end

  assign testReq = (state == ST_TEST);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (testReq && !testDone) |=> testReq); // R3
  AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(doneOut && errOut)); // R11
  AST_QUIET_IN_SWEEP: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_APPLY || state == ST_TEST || state == ST_EVAL) |-> (!doneOut && !errOut)); // R11
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && startReq) |-> !cmd.beginRun); // R8

endmodule

// File: rtl/sweep_tuner.sv
module sweep_tuner
  import sweep_tuner_pkg::*;
#(
  parameter int TUNE_W        = 6,
  parameter int SWEEP_LEN     = 40,
  parameter int APPLY_TIMEOUT = 250
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        cardIsEmmc,
  input  logic        hs200Op,
  input  logic        modeWe,
  input  logic [2:0]  modeIn,
  input  logic        phyAck,
  input  logic        testDone,
  input  logic        testPass,
  output logic [15:0] ctrlReg,
  output logic        testReq,
  output logic        doneOut,
  output logic        errOut
);

  sweepCmd_t cmd;
  logic isLast, noPass, applyTimeout;

  sweep_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .cardIsEmmc(cardIsEmmc),
    .hs200Op(hs200Op), .phyAck(phyAck), .testDone(testDone), .testPass(testPass),
    .isLast(isLast), .noPass(noPass), .applyTimeout(applyTimeout),
    .cmd(cmd), .testReq(testReq), .doneOut(doneOut), .errOut(errOut)
  );

  sweep_datapath #(
    .TUNE_W(TUNE_W), .SWEEP_LEN(SWEEP_LEN), .APPLY_TIMEOUT(APPLY_TIMEOUT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .modeWe(modeWe), .modeIn(modeIn),
    .isLast(isLast), .noPass(noPass), .applyTimeout(applyTimeout), .ctrlReg(ctrlReg)
  );

  AST_NO_TEST_WHILE_UPD: assert property (@(posedge clk) disable iff (!rstN)
    testReq |-> !ctrlReg[UPD_BIT]); // R4

endmodule

// File: tb/sweep_tuner_test.sv
`timescale 1ns/1ps
module sweep_tuner_test;

  localparam int LIM   = 10;
  localparam int LASTI = 39;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0, cardIsEmmc = 1'b1, hs200Op = 1'b1;
  logic modeWe = 1'b0;
  logic [2:0] modeIn = 3'd0;
  logic phyAck = 1'b0, testDone = 1'b0, testPass = 1'b0;
  logic [15:0] ctrlReg;
  logic testReq, doneOut, errOut;

  always #2 clk = ~clk;

  sweep_tuner #(.TUNE_W(6), .SWEEP_LEN(40), .APPLY_TIMEOUT(LIM)) uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .cardIsEmmc(cardIsEmmc),
    .hs200Op(hs200Op), .modeWe(modeWe), .modeIn(modeIn), .phyAck(phyAck),
    .testDone(testDone), .testPass(testPass), .ctrlReg(ctrlReg),
    .testReq(testReq), .doneOut(doneOut), .errOut(errOut)
  );

  int errors = 0, checks = 0;
  bit finished = 0;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: states 0 idle, 1 apply, 2 test, 3 eval, 4 settle
  int mState = 0, mIdx = 0, mTune = 0, mUpd = 0, mMode = 0, mDone = 0, mErr = 0;
  int mCur = 0, mBest = 0, mEnd = 0, mTmr = 0;

  function automatic bit legalCode(input int c);
    return (c == 0 || c == 2 || c == 3 || c == 4 || c == 5 || c == 6);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState = 0; mIdx = 0; mTune = 0; mUpd = 0; mMode = 0; mDone = 0; mErr = 0;
      mCur = 0; mBest = 0; mEnd = 0; mTmr = 0;
    end else begin
      if (modeWe && legalCode(int'(modeIn))) mMode = int'(modeIn);
      case (mState)
        0: if (startReq) begin
             if (cardIsEmmc && hs200Op) begin
               mIdx = 0; mTune = 0; mUpd = 1; mTmr = 0; mCur = 0; mBest = 0; mEnd = 0;
               mDone = 0; mErr = 0; mState = 1;
             end else begin
               mErr = 1; mDone = 0;
             end
           end
        1: if (phyAck) begin mUpd = 0; mState = 2; end
           else if (mTmr == LIM - 1) begin mUpd = 0; mCur = 0; mState = 3; end
           else mTmr++;
        2: if (testDone) begin
             if (testPass) begin
               mCur++;
               if (mCur > mBest) begin mBest = mCur; mEnd = mIdx; end
             end else mCur = 0;
             mState = 3;
           end
        3: if (mIdx == LASTI) begin
             if (mBest == 0) begin mErr = 1; mState = 0; end
             else begin mTune = mEnd - mBest / 2; mUpd = 1; mTmr = 0; mState = 4; end
           end else begin
             mIdx++; mTune = mIdx; mUpd = 1; mTmr = 0; mState = 1;
           end
        4: if (phyAck) begin mUpd = 0; mDone = 1; mState = 0; end
           else if (mTmr == LIM - 1) begin mUpd = 0; mErr = 1; mState = 0; end
           else mTmr++;
        default: mState = 0;
      endcase
    end
  end

  // responder configuration
  logic [39:0] passPat = '0;
  logic [39:0] ackNever = '0;
  bit finalNever = 0;
  int waitCnt = 0, prevSt = -1, prevIdx = -1;
  int reqRises = 0;
  bit prevReq = 0;

  task automatic tick();
    @(negedge clk);
    check("R10 tune field", int'(ctrlReg[13:8]), mTune);
    check("R3 update flag", int'(ctrlReg[15]), mUpd);
    check("R9 mode field", int'(ctrlReg[2:0]), mMode);
    check("R3 testReq", int'(testReq), (mState == 2) ? 1 : 0);
    check("R6 doneOut", int'(doneOut), mDone);
    check("R7 errOut", int'(errOut), mErr);
    if (testReq && !prevReq) reqRises++;
    prevReq = testReq;
    if (mState != prevSt || mIdx != prevIdx) waitCnt = 0; else waitCnt++;
    prevSt = mState; prevIdx = mIdx;
    phyAck = 1'b0; testDone = 1'b0; testPass = passPat[mIdx];
    case (mState)
      1: phyAck = (!ackNever[mIdx] && waitCnt == mIdx % 3);
      2: begin
           testDone = (waitCnt == mIdx % 4 + 1);
           phyAck   = (waitCnt == 0);  // stray ack, must be ignored
         end
      4: phyAck = (!finalNever && waitCnt == 1);
      default: ;
    endcase
  endtask

  task automatic runSweep();
    int n;
    reqRises = 0;
    startReq = 1'b1;
    tick();
    startReq = 1'b0;
    n = 0;
    while (mState != 0) begin
      startReq = (n % 57 == 5);  // R8: start pulses mid-sweep
      tick();
      n++;
    end
    startReq = 1'b0;
    tick();
  endtask

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R1 reset state
    check("R1 ctrlReg", int'(ctrlReg), 0);
    check("R1 testReq", int'(testReq), 0);
    check("R1 doneOut", int'(doneOut), 0);
    check("R1 errOut", int'(errOut), 0);

    // R9 mode writes
    modeWe = 1'b1; modeIn = 3'd4; tick();
    modeIn = 3'd7; tick();
    modeIn = 3'd1; tick();
    modeWe = 1'b0; tick();
    check("R9 illegal codes ignored", int'(ctrlReg[2:0]), 4);
    modeWe = 1'b1; modeIn = 3'd6; tick();
    modeWe = 1'b0; tick();
    check("R9 legal code 6", int'(ctrlReg[2:0]), 6);

    // R2 refused starts
    cardIsEmmc = 1'b0; startReq = 1'b1; tick(); startReq = 1'b0;
    check("R2 err on non-eMMC", int'(errOut), 1);
    check("R2 no test request", int'(testReq), 0);
    repeat (3) tick();
    check("R2 ctrlReg unchanged", int'(ctrlReg), 16'h0006);
    cardIsEmmc = 1'b1; hs200Op = 1'b0; startReq = 1'b1; tick(); startReq = 1'b0;
    check("R2 err on wrong op", int'(errOut), 1);
    check("R2 no update", int'(ctrlReg[15]), 0);
    hs200Op = 1'b1;

    // sweep A: two equal runs 10..20 and 25..35, timeouts at 5 and 38
    passPat = '0;
    for (int i = 10; i <= 20; i++) passPat[i] = 1'b1;
    for (int i = 25; i <= 35; i++) passPat[i] = 1'b1;
    ackNever = '0; ackNever[5] = 1'b1; ackNever[38] = 1'b1;
    finalNever = 0;
    runSweep();
    check("R5 tie keeps earliest run, centre", int'(ctrlReg[13:8]), 15);
    check("R6 done after centre applied", int'(doneOut), 1);
    check("R6 update flag cleared", int'(ctrlReg[15]), 0);
    check("R4 timed-out trials skip test", reqRises, 38);
    check("R8 mid-sweep starts ignored", int'(errOut), 0);
    repeat (4) tick();
    check("R11 done held in idle", int'(doneOut), 1);

    // R11 refused start clears done
    cardIsEmmc = 1'b0; startReq = 1'b1; tick(); startReq = 1'b0; cardIsEmmc = 1'b1;
    check("R11 done cleared by refused start", int'(doneOut), 0);
    check("R11 err set by refused start", int'(errOut), 1);

    // sweep B: nothing passes
    passPat = '0; ackNever = '0;
    runSweep();
    check("R7 err when no pass", int'(errOut), 1);
    check("R7 done low", int'(doneOut), 0);
    check("R7 tune keeps last swept", int'(ctrlReg[13:8]), 39);
    check("R7 no final update", int'(ctrlReg[15]), 0);
    check("R10 all 40 values tested", reqRises, 40);

    // sweep C: single pass at 2, run 30..39
    passPat = '0; passPat[2] = 1'b1;
    for (int i = 30; i <= 39; i++) passPat[i] = 1'b1;
    runSweep();
    check("R6 centre of run ending at last value", int'(ctrlReg[13:8]), 34);
    check("R6 done", int'(doneOut), 1);

    // sweep D: all pass, final update never acknowledged
    passPat = '1; finalNever = 1;
    runSweep();
    check("R6 centre of full run", int'(ctrlReg[13:8]), 19);
    check("R6 final timeout raises err", int'(errOut), 1);
    check("R6 final timeout no done", int'(doneOut), 0);
    check("R4 flag dropped after timeout", int'(ctrlReg[15]), 0);
    check("R9 mode kept through sweeps", int'(ctrlReg[2:0]), 6);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule